// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt sources, numbered 1 to 13. Each cycle it picks the most urgent source that is pending and not masked. It presents that source's 3-bit interrupt level and an 8-bit vector to the processor core. Software sets urgency through an 8-bit control register per source. The low five bits of that register form one rank, and bit 7 selects an autovector. A 16-bit mask register holds a 1 for each blocked source. A read-only pending register shows the sampled source levels.

A source that wins with its autovector bit clear takes its vector from a programmable register. Three sources have such a register: source 8 uses the software vector register, source 12 the first serial vector register, and source 13 the second serial vector register. Every other source falls back to the fixed vector 0x0F. A winning rank below 4 raises nothing. The level and vector outputs are registered, so the core sees a stable pair for a whole cycle. Registers are reached through a simple single-cycle bus: writes take effect on the clock edge and reads are combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending register at offset 0x3A reads bit i (1..13) as the level of source i sampled at the previous rising clock edge. Bits 0, 14 and 15 read 0, and writes to 0x3A have no effect.
- R2: The mask register at offset 0x36 is a 16-bit read/write register whose bit i set to 1 blocks source i.
- R3: When no source is both pending and unmasked, irq_level and irq_vector are both 0.
- R4: Among pending, unmasked sources, the winner is the one whose control bits [4:0] hold the largest value. On equal values the lowest-numbered source wins.
- R5: When the winner's control bits [4:0] are below 4, irq_level and irq_vector are both 0.
- R6: irq_level equals control bits [4:2] of the winning source.
- R7: When bit 7 of the winner's control register is 1, irq_vector equals 24 plus irq_level.
- R8: When bit 7 is 0, irq_vector comes from the register at 0x44 for source 8, from 0x45 for source 12 and from 0x46 for source 13. Any other source gets 0x0F.
- R9: After reset the mask reads 0x3FFE. Control registers 1..7 read 4 times the source number, source 8 reads 0x1C, sources 9..11 read 0x80, and sources 12..13 read 0x00. Register 0x44 reads 0x0F, 0x45 and 0x46 read 0x00, the pending register reads 0, and both outputs are 0.
- R10: The control register of source i sits at byte offset 0x13+i. It is written from wdata[7:0] and read back with the upper byte 0. An unmapped offset reads 0, and a write to it changes no register.
- R11: A change on a source input is reflected in the outputs after two rising edges. A register write is reflected one edge after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 13 | Source levels, bit i is source i (bits 13:1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq_level | output | 3 | Registered interrupt level of the winner |
| irq_vector | output | 8 | Registered interrupt vector of the winner |

## Verification
A change on a source is captured into the pending register on the first rising edge and reaches irq_level and irq_vector on the second. A register write is captured on its edge and reaches the outputs on the following one. Read data depends only on the current offset. The bench drives every input on a falling edge. It samples the outputs on the falling edge after the second rising edge following a source change. In the two timing checks it also samples one edge earlier to confirm that the old value still holds. Register reads are checked one time unit after the offset is set, with no clock edge in between.

// File: rtl/irq_prio_pkg.sv
// Package: shared widths, register offsets and reset values for the
// prioritized vectored interrupt controller.
package irq_prio_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int CTRL_W   = 8;
    localparam int RANK_W   = 5;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;

    // Register offsets (byte addresses on the register bus)
    localparam int CTRL_BASE  = 'h14;   // source 1; source i at CTRL_BASE+i-1
    localparam int MASK_ADDR  = 'h36;
    localparam int PEND_ADDR  = 'h3A;
    localparam int SWVEC_ADDR = 'h44;
    localparam int SER0_ADDR  = 'h45;
    localparam int SER1_ADDR  = 'h46;

    localparam logic [DATA_W-1:0] MASK_RST   = 16'h3FFE;
    localparam logic [VEC_W-1:0]  SWVEC_RST  = 8'h0F;
    localparam logic [VEC_W-1:0]  SERVEC_RST = 8'h00;

    // Reset value of the control register for a given source number
    function automatic logic [CTRL_W-1:0] ctrl_rst(input int idx);
        if (idx <= 7)
            return CTRL_W'(idx * 4);
        else if (idx == 8)
            return 8'h1C;
        else if (idx <= 11)
            return 8'h80;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/irq_regfile.sv
// Register file: pending capture, mask, per-source control and vector
// registers, with a combinational read mux.
// Assumes one write per cycle and byte offsets from irq_prio_pkg.
module irq_regfile
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC:1]              src_lvl,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic [NUM_SRC:1]              pend_q,
    output logic [DATA_W-1:0]             mask_q,
    output logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_q,
    output logic [VEC_W-1:0]              sw_vec_q,
    output logic [VEC_W-1:0]              ser0_vec_q,
    output logic [VEC_W-1:0]              ser1_vec_q
);

    logic [NUM_SRC:1] ctrl_sel;
    logic             mask_sel, pend_sel, swv_sel, s0_sel, s1_sel;

    // Per-source address decode for the control registers
    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_dec
        assign ctrl_sel[g] = (reg_addr == ADDR_W'(CTRL_BASE + g - 1));
    end

    assign mask_sel = (reg_addr == ADDR_W'(MASK_ADDR));
    assign pend_sel = (reg_addr == ADDR_W'(PEND_ADDR));
    assign swv_sel  = (reg_addr == ADDR_W'(SWVEC_ADDR));
    assign s0_sel   = (reg_addr == ADDR_W'(SER0_ADDR));
    assign s1_sel   = (reg_addr == ADDR_W'(SER1_ADDR));

    // Pending bits follow the source levels, one sample per clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= src_lvl;
    end

    // Mask register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_RST;
        else if (reg_we && mask_sel)
            mask_q <= reg_wdata;
    end

    // Control register writes, one byte per source
    always_ff @(posedge clk) begin
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (!rst_n)
                ctrl_q[i] <= ctrl_rst(i);
            else if (reg_we && ctrl_sel[i])
                ctrl_q[i] <= reg_wdata[CTRL_W-1:0];
        end
    end

    // Programmable vector register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_vec_q   <= SWVEC_RST;
            ser0_vec_q <= SERVEC_RST;
            ser1_vec_q <= SERVEC_RST;
        end else if (reg_we) begin
            if (swv_sel) sw_vec_q   <= reg_wdata[VEC_W-1:0];
            if (s0_sel)  ser0_vec_q <= reg_wdata[VEC_W-1:0];
            if (s1_sel)  ser1_vec_q <= reg_wdata[VEC_W-1:0];
        end
    end

    // Read data mux; unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        if (mask_sel)
            reg_rdata = mask_q;
        else if (pend_sel)
            reg_rdata = DATA_W'({pend_q, 1'b0});
        else if (swv_sel)
            reg_rdata = DATA_W'(sw_vec_q);
        else if (s0_sel)
            reg_rdata = DATA_W'(ser0_vec_q);
        else if (s1_sel)
            reg_rdata = DATA_W'(ser1_vec_q);
        else begin
            for (int i = 1; i <= NUM_SRC; i++)
                if (ctrl_sel[i])
                    reg_rdata = DATA_W'(ctrl_q[i]);
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Priority search: picks the unmasked pending source with the largest
// rank (control bits [4:0]); ties go to the lowest source number.
// Purely combinational; a rank below MIN_RANK yields no winner.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC  = 13,
    parameter int MIN_RANK = 4,
    localparam int IW      = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]              pend,
    input  logic [NUM_SRC:1]              mask,
    input  logic [NUM_SRC:1][CTRL_W-1:0]  ctrl,
    output logic                          win_valid,
    output logic [IW-1:0]                 win_idx,
    output logic [LVL_W-1:0]              win_level,
    output logic                          win_auto
);

    logic [NUM_SRC:1]   active;
    logic [RANK_W-1:0]  best_rank;
    logic [CTRL_W-1:0]  best_ctrl;
    logic               unused_ctrl_bits;

    assign active = pend & ~mask;

    // Linear scan; strict greater-than keeps the lowest index on a tie
    always_comb begin
        best_rank = '0;
        best_ctrl = '0;
        win_idx   = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && (ctrl[i][RANK_W-1:0] > best_rank)) begin
                best_rank = ctrl[i][RANK_W-1:0];
                best_ctrl = ctrl[i];
                win_idx   = IW'(i);
            end
        end
    end

    // Threshold and field extraction for the winner
    always_comb begin
        win_valid = (best_rank >= RANK_W'(MIN_RANK));
        win_level = win_valid ? best_ctrl[RANK_W-1:RANK_W-LVL_W] : '0;
        win_auto  = win_valid & best_ctrl[CTRL_W-1];
    end

    assign unused_ctrl_bits = ^best_ctrl[CTRL_W-2:RANK_W];

endmodule

// File: rtl/irq_vector_gen.sv
// Vector generation and output register: forms the vector for the
// arbitration winner and registers level and vector together.
module irq_vector_gen
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int AUTO_BASE = 24,
    parameter int DEF_VEC   = 'h0F,
    parameter int SW_SRC    = 8,
    parameter int SER0_SRC  = 12,
    parameter int SER1_SRC  = 13,
    localparam int IW       = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  logic [IW-1:0]      win_idx,
    input  logic [LVL_W-1:0]   win_level,
    input  logic               win_auto,
    input  logic [VEC_W-1:0]   sw_vec,
    input  logic [VEC_W-1:0]   ser0_vec,
    input  logic [VEC_W-1:0]   ser1_vec,
    output logic [LVL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]   irq_vector
);

    logic [VEC_W-1:0] vec_nxt;

    // Vector select: none, autovector, programmable or default
    always_comb begin
        if (!win_valid)
            vec_nxt = '0;
        else if (win_auto)
            vec_nxt = VEC_W'(AUTO_BASE) + VEC_W'(win_level);
        else if (win_idx == IW'(SW_SRC))
            vec_nxt = sw_vec;
        else if (win_idx == IW'(SER0_SRC))
            vec_nxt = ser0_vec;
        else if (win_idx == IW'(SER1_SRC))
            vec_nxt = ser1_vec;
        else
            vec_nxt = VEC_W'(DEF_VEC);
    end

    // Output register for level and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            irq_level  <= win_level;
            irq_vector <= vec_nxt;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top: prioritized vectored interrupt controller. Connects the register
// file, the priority search and the registered vector stage.
// Assumes source levels are synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int MIN_RANK  = 4,
    parameter int AUTO_BASE = 24,
    parameter int DEF_VEC   = 'h0F,
    parameter int SW_SRC    = 8,
    parameter int SER0_SRC  = 12,
    parameter int SER1_SRC  = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC:1]    src_lvl,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [LVL_W-1:0]    irq_level,
    output logic [VEC_W-1:0]    irq_vector
);

    localparam int IW = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1]              pend_q;
    logic [DATA_W-1:0]             mask_q;
    logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_q;
    logic [VEC_W-1:0]              sw_vec_q, ser0_vec_q, ser1_vec_q;
    logic                          arb_valid, arb_auto;
    logic [IW-1:0]                 arb_idx;
    logic [LVL_W-1:0]              arb_level;
    logic                          unused_mask_bits;

    assign unused_mask_bits = mask_q[0] ^ (^mask_q[DATA_W-1:NUM_SRC+1]);

    irq_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl    (src_lvl),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .ctrl_q     (ctrl_q),
        .sw_vec_q   (sw_vec_q),
        .ser0_vec_q (ser0_vec_q),
        .ser1_vec_q (ser1_vec_q)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .MIN_RANK(MIN_RANK)) u_arb (
        .pend      (pend_q),
        .mask      (mask_q[NUM_SRC:1]),
        .ctrl      (ctrl_q),
        .win_valid (arb_valid),
        .win_idx   (arb_idx),
        .win_level (arb_level),
        .win_auto  (arb_auto)
    );

    irq_vector_gen #(
        .NUM_SRC   (NUM_SRC),
        .AUTO_BASE (AUTO_BASE),
        .DEF_VEC   (DEF_VEC),
        .SW_SRC    (SW_SRC),
        .SER0_SRC  (SER0_SRC),
        .SER1_SRC  (SER1_SRC)
    ) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (arb_valid),
        .win_idx    (arb_idx),
        .win_level  (arb_level),
        .win_auto   (arb_auto),
        .sw_vec     (sw_vec_q),
        .ser0_vec   (ser0_vec_q),
        .ser1_vec   (ser1_vec_q),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Checker: temporal properties of the interrupt controller, bound to
// the top module. Observes ports and the nets between its stages.
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int AUTO_BASE = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC:1]   src_lvl,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_SRC:1]   pend_q,
    input logic [DATA_W-1:0]  mask_q,
    input logic               arb_valid,
    input logic               arb_auto,
    input logic [LVL_W-1:0]   irq_level,
    input logic [VEC_W-1:0]   irq_vector
);

    // R1: pending bits track the source levels one clock later
    assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q == $past(src_lvl)));

    // R2: a mask write lands in the mask register
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(MASK_ADDR)) |=> (mask_q == $past(reg_wdata)));

    // R3: no active source gives zero level and vector
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q & ~mask_q[NUM_SRC:1]) == '0) |-> (irq_level == '0 && irq_vector == '0));

    // R5: without a qualified winner the outputs are zero
    assert_no_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(arb_valid) |-> (irq_level == '0 && irq_vector == '0));

    // R6: a qualified winner always presents a nonzero level
    assert_level_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(arb_valid)) |-> (irq_level != '0));

    // R7: autovector equals base plus level
    assert_autovec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(arb_auto)) |-> (irq_vector == VEC_W'(AUTO_BASE) + VEC_W'(irq_level)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .AUTO_BASE (AUTO_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .arb_valid  (arb_valid),
    .arb_auto   (arb_auto),
    .irq_level  (irq_level),
    .irq_vector (irq_vector)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
// Bench: vector table walk followed by directed reset, timing and
// vector-source tests for the interrupt controller.
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] src_lvl = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl    (src_lvl),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    // Layout: {sources[15:0], mask[15:0], level[7:0], vector[7:0]}
    localparam logic [47:0] VECS [0:8] = '{
        48'h0002_0000_01_0F,   // R4 single source 1
        48'h000A_0000_03_0F,   // R4 sources 1,3 -> 3
        48'h0180_0000_07_0F,   // R4 tie 7,8 -> 7
        48'h0180_0080_07_0F,   // R2 mask 7 -> 8, reset sw vector
        48'h0200_0000_00_00,   // R5 source 9 rank 0
        48'h3FFE_3FFE_00_00,   // R3 all masked
        48'h0024_0020_02_0F,   // R2 mask 5 -> 2
        48'h3FFE_0000_07_0F,   // R4 all active -> 7
        48'h0000_0000_00_00    // R3 nothing pending
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic out_chk(input string tag, input logic [2:0] lvl, input logic [7:0] vec);
        chk({tag, " level"}, 16'(irq_level), 16'(lvl));
        chk({tag, " vector"}, 16'(irq_vector), 16'(vec));
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic set_src(input logic [15:0] v);
        src_lvl = v[13:1];
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset values
        out_chk("R9 reset outputs", 3'd0, 8'h00);
        rd_chk("R9 mask reset", 8'h36, 16'h3FFE);
        rd_chk("R9 ctrl1 reset", 8'h14, 16'h0004);
        rd_chk("R9 ctrl7 reset", 8'h1A, 16'h001C);
        rd_chk("R9 ctrl8 reset", 8'h1B, 16'h001C);
        rd_chk("R9 ctrl9 reset", 8'h1C, 16'h0080);
        rd_chk("R9 ctrl12 reset", 8'h1F, 16'h0000);
        rd_chk("R9 swvec reset", 8'h44, 16'h000F);
        rd_chk("R9 ser0 reset", 8'h45, 16'h0000);
        rd_chk("R9 pend reset", 8'h3A, 16'h0000);
        @(negedge clk);

        // Vector table walk (R2 R3 R4 R5)
        for (int k = 0; k <= 8; k++) begin
            wr(8'h36, VECS[k][31:16]);
            set_src(VECS[k][47:32]);
            out_chk($sformatf("R4 table[%0d]", k), VECS[k][10:8], VECS[k][7:0]);
        end

        // R1 pending readback and write ignored
        src_lvl = 13'h1555;
        @(posedge clk); @(negedge clk);
        rd_chk("R1 pend read", 8'h3A, 16'h2AAA);
        wr(8'h3A, 16'hFFFF);
        rd_chk("R1 pend write ignored", 8'h3A, 16'h2AAA);
        src_lvl = 13'h1FFF;
        @(posedge clk); @(negedge clk);
        rd_chk("R1 pend all", 8'h3A, 16'h3FFE);
        set_src(16'h0000);

        // R11 source timing: source 4 rank 0x10 -> level 4
        src_lvl = 13'h0008;
        @(posedge clk); @(negedge clk);
        out_chk("R11 src edge1", 3'd0, 8'h00);
        @(posedge clk); @(negedge clk);
        out_chk("R11 src edge2", 3'd4, 8'h0F);

        // R11 write timing and R6 level field: ctrl4 = 0x1A -> level 6
        wr(8'h17, 16'h001A);
        out_chk("R11 wr edge1", 3'd4, 8'h0F);
        @(posedge clk); @(negedge clk);
        out_chk("R6 wr edge2", 3'd6, 8'h0F);
        set_src(16'h0000);

        // R7 autovector: ctrl9 = 0x94 -> level 5, vector 29
        wr(8'h1C, 16'h0094);
        set_src(16'h0200);
        out_chk("R7 auto src9", 3'd5, 8'h1D);

        // R8 programmable vectors
        wr(8'h44, 16'h0040);
        set_src(16'h0100);
        out_chk("R8 sw vector src8", 3'd7, 8'h40);
        wr(8'h1F, 16'h0010);
        wr(8'h45, 16'h0055);
        set_src(16'h1000);
        out_chk("R8 ser0 vector src12", 3'd4, 8'h55);
        wr(8'h20, 16'h0018);
        wr(8'h46, 16'h0066);
        set_src(16'h2000);
        out_chk("R8 ser1 vector src13", 3'd6, 8'h66);
        wr(8'h20, 16'h0098);
        set_src(16'h2000);
        out_chk("R7 auto src13", 3'd6, 8'h1E);

        // R5 rank below threshold
        wr(8'h14, 16'h0003);
        set_src(16'h0002);
        out_chk("R5 rank3", 3'd0, 8'h00);

        // R4 full 5-bit rank decides: ctrl8 0x1D beats ctrl7 0x1C
        wr(8'h1B, 16'h001D);
        set_src(16'h0180);
        out_chk("R4 low rank bit", 3'd7, 8'h40);

        // R4 tie goes to lowest: ctrl1 0x9C ties ctrl7 0x1C
        wr(8'h14, 16'h009C);
        set_src(16'h0082);
        out_chk("R4 tie lowest", 3'd7, 8'h1F);

        // R10 byte write, unmapped offset
        wr(8'h15, 16'hABCD);
        rd_chk("R10 ctrl2 byte", 8'h15, 16'h00CD);
        rd_chk("R10 unmapped read", 8'h50, 16'h0000);
        wr(8'h50, 16'h1234);
        rd_chk("R10 unmapped write", 8'h36, 16'h0000);
        rd_chk("R10 unmapped write vec", 8'h44, 16'h0040);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule